// File: doc/BRIEF.md
# Greedy Cluster Frequency Allocator

This controller sets one frequency code per voltage/clock cluster on a 16-core chip. The cores are split into `CLUSTERS` groups of equal size, and each group shares one regulator. A start pulse captures a snapshot of several inputs: each cluster's power measured at the nominal frequency, each cluster's scalability score, a chip-wide power budget, and a current limit that applies to every regulator. The block then works through the clusters one at a time. When the nominal operating point fits inside the budget, the cluster with the highest scalability takes spare headroom first. It climbs until the first of three limits binds: the remaining budget, its regulator limit, or the maximum code. When even the nominal point exceeds the budget, clusters are slowed instead. This starts with the least scalable cluster and goes no lower than the quality-of-service floor.

Power at a candidate code is estimated from the measured power at nominal frequency. The estimate scales with the square of frequency, which makes it exact at the nominal code, four times larger at the ceiling and one quarter at the floor. The new codes appear on the outputs together with a one-cycle done pulse. The run takes a fixed number of cycles.

Top module: `cluster_freq_alloc`

## Requirements
- R1: While reset is asserted, and after it is released, every frequency code reads 64, and busy and done are both 0.
- R2: A start sampled while idle raises busy. With N clusters, done is a single-cycle pulse exactly N + N·(N+9) + 1 clock edges after the start edge (57 for N = 4). Busy falls on that same edge.
- R3: Frequency outputs change only on the edge that raises done. In every other cycle they hold their previous values.
- R4: Start pulses and input changes that arrive while busy have no effect. The codes delivered reflect only the inputs captured at the accepted start.
- R5: Encoding: code 64 is the nominal frequency. Estimated cluster power at code f is floor(p·f²/4096), where p is the 8-bit power input. If the sum of p over all clusters does not exceed the budget, every code lies in 64..128 and the summed estimate stays within the budget.
- R6: In raise mode, clusters are served in descending scalability order, with equal scores served lower index first. Each is given the largest code its remaining headroom allows.
- R7: In raise mode, a cluster moved above 64 has an estimate no greater than the regulator limit input.
- R8: No code exceeds 128. With ample budget and limit, every cluster reaches 128.
- R9: If the sum of p exceeds the budget, clusters are served in ascending scalability order, with ties going to the lower index. Each gets the largest code in 32..64 that keeps the running total within budget, or 32 if none does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture inputs and begin an allocation (ignored while busy) |
| budget_i | input | TW (13) | Chip-wide power budget in estimate units |
| reg_limit_i | input | PW+2 (10) | Per-regulator limit in estimate units |
| power_i | input | CLUSTERS·PW (32) | Per-cluster measured power at code 64, cluster 0 in the low bits |
| scal_i | input | CLUSTERS·SW (32) | Per-cluster scalability, 255 = 100% |
| freq_o | output | CLUSTERS·FW (32) | Per-cluster frequency codes |
| busy_o | output | 1 | Allocation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the done pulse that publishes a finished result, and a start that launches the next run. The bench holds start high across the end of a run, having changed the inputs while the block was busy. It checks three things. The start sampled on the finishing edge must be dropped. The start sampled during the done cycle must be accepted and must use the new inputs. The codes just published must stay unchanged until the second done pulse. A reference model compares busy, done and every code on every clock.

// File: rtl/fba_pkg.sv
package fba_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM,
        ST_PICK,
        ST_LOAD,
        ST_SRCH,
        ST_COMMIT,
        ST_FINISH
    } alloc_state_e;
endpackage

// File: rtl/fba_power_est.sv
module fba_power_est #(
    parameter int PW    = 8,
    parameter int FW    = 8,
    parameter int F_MIN = 64,
    localparam int EW   = PW + 2
) (
    input  logic [PW-1:0] pwr_i,
    input  logic [FW-1:0] freq_i,
    output logic [EW-1:0] est_o
);
    localparam int SH     = 2 * $clog2(F_MIN);
    localparam int PROD_W = PW + 2 * FW;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;

    // Square-law estimate relative to the nominal code; saturates on overflow.
    always_comb begin
        prod   = PROD_W'(pwr_i) * PROD_W'(freq_i) * PROD_W'(freq_i);
        scaled = prod >> SH;
        if (|scaled[PROD_W-1:EW]) est_o = '1;
        else                      est_o = scaled[EW-1:0];
    end
endmodule

// File: rtl/fba_scan.sv
module fba_scan #(
    parameter int N  = 4,
    parameter int SW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          en_i,
    input  logic [IW-1:0] idx_i,
    input  logic [SW-1:0] score_i,
    input  logic          skip_i,
    input  logic          want_low_i,
    output logic [IW-1:0] best_o,
    output logic          found_o
);
    typedef struct packed {
        logic [IW-1:0] idx;
        logic [SW-1:0] score;
        logic          found;
    } scan_t;

    scan_t scan_d, scan_q;
    logic  better;

    // Strict comparison: an equal score never displaces an earlier index.
    always_comb begin
        scan_d = scan_q;
        better = want_low_i ? (score_i < scan_q.score) : (score_i > scan_q.score);
        if (clear_i) begin
            scan_d.found = 1'b0;
        end else if (en_i && !skip_i && (!scan_q.found || better)) begin
            scan_d.idx   = idx_i;
            scan_d.score = score_i;
            scan_d.found = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) scan_q <= '0;
        else         scan_q <= scan_d;
    end

    assign best_o  = scan_q.idx;
    assign found_o = scan_q.found;

    // R6: a cleared scan holds no winner on the following cycle
    assert_clear_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> !found_o);
endmodule

// File: rtl/fba_search.sv
module fba_search #(
    parameter int PW    = 8,
    parameter int FW    = 8,
    parameter int CW    = 15,
    parameter int F_MIN = 64,
    localparam int EW   = PW + 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 load_i,
    input  logic [FW-1:0]        lo_i,
    input  logic [FW-1:0]        hi_i,
    input  logic signed [CW-1:0] cap_i,
    input  logic [PW-1:0]        pwr_i,
    output logic [FW-1:0]        result_o
);
    typedef struct packed {
        logic [FW-1:0]        low;
        logic [FW-1:0]        high;
        logic signed [CW-1:0] cap;
        logic [PW-1:0]        pwr;
    } srch_t;

    srch_t         srch_d, srch_q;
    logic [FW:0]   span_sum;
    logic [FW-1:0] mid;
    logic [EW-1:0] est_mid;
    logic          fits;

    fba_power_est #(.PW(PW), .FW(FW), .F_MIN(F_MIN)) u_est_mid (
        .pwr_i (srch_q.pwr),
        .freq_i(mid),
        .est_o (est_mid)
    );

    // Upper-biased bisection: converges on the largest code whose estimate fits.
    always_comb begin
        srch_d   = srch_q;
        span_sum = {1'b0, srch_q.low} + {1'b0, srch_q.high} + 1'b1;
        mid      = span_sum[FW:1];
        fits     = $signed(CW'(est_mid)) <= srch_q.cap;
        if (load_i) begin
            srch_d.low  = lo_i;
            srch_d.high = hi_i;
            srch_d.cap  = cap_i;
            srch_d.pwr  = pwr_i;
        end else if (srch_q.low < srch_q.high) begin
            if (fits) srch_d.low  = mid;
            else      srch_d.high = mid - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            srch_q      <= '0;
            srch_q.low  <= FW'(F_MIN);
            srch_q.high <= FW'(F_MIN);
        end else begin
            srch_q <= srch_d;
        end
    end

    assign result_o = srch_q.low;

    // R9: the search window never inverts
    assert_window_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srch_q.low <= srch_q.high);
endmodule

// File: rtl/cluster_freq_alloc.sv
module cluster_freq_alloc
    import fba_pkg::*;
#(
    parameter int CORES    = 16,
    parameter int CLUSTERS = 4,
    parameter int PW       = 8,
    parameter int SW       = 8,
    parameter int FW       = 8,
    parameter int F_MIN    = 64,
    localparam int EW      = PW + 2,
    localparam int IW      = (CLUSTERS > 1) ? $clog2(CLUSTERS) : 1,
    localparam int TW      = EW + IW + 1,
    localparam int CW      = TW + 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   start_i,
    input  logic [TW-1:0]          budget_i,
    input  logic [EW-1:0]          reg_limit_i,
    input  logic [CLUSTERS*PW-1:0] power_i,
    input  logic [CLUSTERS*SW-1:0] scal_i,
    output logic [CLUSTERS*FW-1:0] freq_o,
    output logic                   busy_o,
    output logic                   done_o
);
    localparam int F_FLOOR = F_MIN / 2;
    localparam int F_MAX   = F_MIN * 2;
    localparam int STEPS   = $clog2(F_MIN + 1);
    localparam int STW     = $clog2(STEPS + 1);
    localparam int PER_CLUSTER_CORES = CORES / CLUSTERS;

    typedef struct packed {
        alloc_state_e                   state;
        logic [IW-1:0]                  cnt;
        logic [IW-1:0]                  ndone;
        logic [STW-1:0]                 step;
        logic [IW-1:0]                  sel;
        logic                           lower;
        logic [TW-1:0]                  total;
        logic [TW-1:0]                  budget;
        logic [EW-1:0]                  ilim;
        logic [CLUSTERS-1:0][PW-1:0]    pwr;
        logic [CLUSTERS-1:0][SW-1:0]    scal;
        logic [CLUSTERS-1:0]            taken;
        logic [CLUSTERS-1:0][FW-1:0]    work;
        logic [CLUSTERS-1:0][FW-1:0]    freq;
        logic                           busy;
        logic                           done;
    } alloc_t;

    alloc_t alloc_d, alloc_q;

    logic [CLUSTERS-1:0][PW-1:0] pwr_in;
    logic [CLUSTERS-1:0][SW-1:0] scal_in;

    genvar gi;
    generate
        for (gi = 0; gi < CLUSTERS; gi++) begin : g_lane
            assign pwr_in[gi]                 = power_i[gi*PW +: PW];
            assign scal_in[gi]                = scal_i[gi*SW +: SW];
            assign freq_o[gi*FW +: FW]        = alloc_q.freq[gi];

            // R8 and R9: every published code sits between floor and ceiling
            assert_code_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (alloc_q.freq[gi] >= FW'(F_FLOOR)) && (alloc_q.freq[gi] <= FW'(F_MAX)));
        end
    endgenerate

    // Ranking scan
    logic [IW-1:0] best_idx;
    logic          best_found;
    logic          scan_clear;
    logic          scan_en;

    assign scan_clear = (alloc_q.state == ST_SUM) || (alloc_q.state == ST_COMMIT);
    assign scan_en    = (alloc_q.state == ST_PICK);

    fba_scan #(.N(CLUSTERS), .SW(SW)) u_scan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (scan_clear),
        .en_i      (scan_en),
        .idx_i     (alloc_q.cnt),
        .score_i   (alloc_q.scal[alloc_q.cnt]),
        .skip_i    (alloc_q.taken[alloc_q.cnt]),
        .want_low_i(alloc_q.lower),
        .best_o    (best_idx),
        .found_o   (best_found)
    );

    // Frequency search for the chosen cluster
    logic                 srch_load;
    logic [FW-1:0]        srch_lo, srch_hi, srch_res;
    logic signed [CW-1:0] cap_raw, cap;
    logic [PW-1:0]        pwr_best, pwr_sel;
    logic [EW-1:0]        est_res;

    assign srch_load = (alloc_q.state == ST_LOAD);
    assign pwr_best  = alloc_q.pwr[best_idx];
    assign pwr_sel   = alloc_q.pwr[alloc_q.sel];
    assign srch_lo   = alloc_q.lower ? FW'(F_FLOOR) : FW'(F_MIN);
    assign srch_hi   = alloc_q.lower ? FW'(F_MIN)   : FW'(F_MAX);

    // Headroom for the chosen cluster: its own nominal share plus the slack.
    always_comb begin
        cap_raw = CW'(pwr_best) + CW'(alloc_q.budget) - CW'(alloc_q.total);
        cap     = cap_raw;
        if (!alloc_q.lower && ($signed(CW'(alloc_q.ilim)) < cap_raw))
            cap = CW'(alloc_q.ilim);
    end

    fba_search #(.PW(PW), .FW(FW), .CW(CW), .F_MIN(F_MIN)) u_search (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (srch_load),
        .lo_i    (srch_lo),
        .hi_i    (srch_hi),
        .cap_i   (cap),
        .pwr_i   (pwr_best),
        .result_o(srch_res)
    );

    fba_power_est #(.PW(PW), .FW(FW), .F_MIN(F_MIN)) u_est_res (
        .pwr_i (pwr_sel),
        .freq_i(srch_res),
        .est_o (est_res)
    );

    // Sequencer
    logic [TW-1:0] sum_next;

    always_comb begin
        alloc_d      = alloc_q;
        alloc_d.done = 1'b0;
        sum_next     = alloc_q.total + TW'(alloc_q.pwr[alloc_q.cnt]);
        unique case (alloc_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    alloc_d.budget = budget_i;
                    alloc_d.ilim   = reg_limit_i;
                    alloc_d.pwr    = pwr_in;
                    alloc_d.scal   = scal_in;
                    alloc_d.total  = '0;
                    alloc_d.cnt    = '0;
                    alloc_d.ndone  = '0;
                    alloc_d.taken  = '0;
                    for (int c = 0; c < CLUSTERS; c++) alloc_d.work[c] = FW'(F_MIN);
                    alloc_d.busy   = 1'b1;
                    alloc_d.state  = ST_SUM;
                end
            end
            ST_SUM: begin
                alloc_d.total = sum_next;
                if (alloc_q.cnt == IW'(CLUSTERS - 1)) begin
                    alloc_d.cnt   = '0;
                    alloc_d.lower = sum_next > alloc_q.budget;
                    alloc_d.state = ST_PICK;
                end else begin
                    alloc_d.cnt = alloc_q.cnt + 1'b1;
                end
            end
            ST_PICK: begin
                if (alloc_q.cnt == IW'(CLUSTERS - 1)) begin
                    alloc_d.cnt   = '0;
                    alloc_d.state = ST_LOAD;
                end else begin
                    alloc_d.cnt = alloc_q.cnt + 1'b1;
                end
            end
            ST_LOAD: begin
                alloc_d.sel   = best_idx;
                alloc_d.step  = '0;
                alloc_d.state = ST_SRCH;
            end
            ST_SRCH: begin
                alloc_d.step = alloc_q.step + 1'b1;
                if (alloc_q.step == STW'(STEPS - 1)) alloc_d.state = ST_COMMIT;
            end
            ST_COMMIT: begin
                alloc_d.work[alloc_q.sel]  = srch_res;
                alloc_d.taken[alloc_q.sel] = 1'b1;
                alloc_d.total = alloc_q.total + TW'(est_res) - TW'(pwr_sel);
                if (alloc_q.ndone == IW'(CLUSTERS - 1)) begin
                    alloc_d.state = ST_FINISH;
                end else begin
                    alloc_d.ndone = alloc_q.ndone + 1'b1;
                    alloc_d.state = ST_PICK;
                end
            end
            ST_FINISH: begin
                alloc_d.freq  = alloc_q.work;
                alloc_d.done  = 1'b1;
                alloc_d.busy  = 1'b0;
                alloc_d.state = ST_IDLE;
            end
            default: alloc_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            alloc_q       <= '0;
            alloc_q.state <= ST_IDLE;
            for (int c = 0; c < CLUSTERS; c++) begin
                alloc_q.freq[c] <= FW'(F_MIN);
                alloc_q.work[c] <= FW'(F_MIN);
            end
        end else begin
            alloc_q <= alloc_d;
        end
    end

    assign busy_o = alloc_q.busy;
    assign done_o = alloc_q.done;

    // R2: done lasts exactly one cycle and never overlaps busy
    assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    assert_done_not_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R3: codes move only together with done
    assert_codes_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(freq_o));

    // R4: captured operands stay put for the whole run
    assert_capture_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> ($stable(alloc_q.budget) && $stable(alloc_q.pwr) && $stable(alloc_q.scal)));

    // R5: raise mode never ends above the budget
    assert_budget_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((alloc_q.state == ST_FINISH) && !alloc_q.lower) |-> (alloc_q.total <= alloc_q.budget));

    // R6: the scan always holds a winner when the search is loaded
    assert_winner_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srch_load |-> best_found);

    // R7: a raised cluster respects its regulator limit
    assert_regulator_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((alloc_q.state == ST_COMMIT) && !alloc_q.lower)
            |-> ((est_res <= alloc_q.ilim) || (srch_res == FW'(F_MIN))));

    initial begin
        assert_even_split_R1: assert (PER_CLUSTER_CORES * CLUSTERS == CORES);
    end
endmodule

// File: tb/cluster_freq_alloc_test.sv
module cluster_freq_alloc_test;
    localparam int N    = 4;
    localparam int PW   = 8;
    localparam int SW   = 8;
    localparam int FW   = 8;
    localparam int EW   = PW + 2;
    localparam int TW   = EW + 2 + 1;
    localparam int LAT  = N + N * (N + 9) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [TW-1:0]     budget;
    logic [EW-1:0]     reg_limit;
    logic [N*PW-1:0]   power;
    logic [N*SW-1:0]   scal;
    logic [N*FW-1:0]   freq;
    logic              busy, done;

    int p_in[N];
    int s_in[N];
    int bud_in;
    int lim_in;

    int checks = 0;
    int fails  = 0;

    bit m_busy = 1'b0;
    bit m_done = 1'b0;
    int m_cnt  = 0;
    int m_freq[N];
    int m_pend[N];

    always #10 clk = ~clk;

    always_comb begin
        for (int c = 0; c < N; c++) begin
            power[c*PW +: PW] = PW'(p_in[c]);
            scal[c*SW +: SW]  = SW'(s_in[c]);
        end
        budget    = TW'(bud_in);
        reg_limit = EW'(lim_in);
    end

    cluster_freq_alloc uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .budget_i   (budget),
        .reg_limit_i(reg_limit),
        .power_i    (power),
        .scal_i     (scal),
        .freq_o     (freq),
        .busy_o     (busy),
        .done_o     (done)
    );

    function automatic int est(int p, int f);
        return (p * f * f) / 4096;
    endfunction

    // Behavioural reference of the greedy allocation (R5..R9).
    task automatic reference();
        int  total = 0;
        bit  taken[N];
        bit  lower;
        for (int c = 0; c < N; c++) begin
            total += p_in[c];
            taken[c] = 1'b0;
            m_pend[c] = 64;
        end
        lower = total > bud_in;
        for (int k = 0; k < N; k++) begin
            int pick = -1;
            int cap, lo, hi, f;
            for (int c = 0; c < N; c++) begin
                if (!taken[c]) begin
                    if (pick < 0) pick = c;
                    else if (lower && s_in[c] < s_in[pick]) pick = c;
                    else if (!lower && s_in[c] > s_in[pick]) pick = c;
                end
            end
            cap = p_in[pick] + bud_in - total;
            if (!lower && lim_in < cap) cap = lim_in;
            lo = lower ? 32 : 64;
            hi = lower ? 64 : 128;
            f  = lo;
            for (int ff = lo; ff <= hi; ff++) if (est(p_in[pick], ff) <= cap) f = ff;
            m_pend[pick] = f;
            taken[pick]  = 1'b1;
            total = total + est(p_in[pick], f) - p_in[pick];
        end
    endtask

    task automatic compare(string tag);
        checks++;
        if (busy !== m_busy || done !== m_done) begin
            fails++;
            $display("FAIL R2 busy/done actual=%b/%b expected=%b/%b", busy, done, m_busy, m_done);
        end
        for (int c = 0; c < N; c++) begin
            checks++;
            if (freq[c*FW +: FW] !== FW'(m_freq[c])) begin
                fails++;
                $display("FAIL %s freq[%0d] actual=%0d expected=%0d", tag, c, freq[c*FW +: FW], m_freq[c]);
            end
        end
    endtask

    // Predict the effect of the coming edge, then sample at the next falling edge.
    task automatic tick(string tag);
        m_done = 1'b0;
        if (m_busy) begin
            m_cnt++;
            if (m_cnt == LAT) begin
                m_busy = 1'b0;
                m_done = 1'b1;
                for (int c = 0; c < N; c++) m_freq[c] = m_pend[c];
            end
        end else if (start) begin
            m_busy = 1'b1;
            m_cnt  = 0;
            reference();
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run(string tag);
        start = 1'b1;
        tick(tag);
        start = 1'b0;
        repeat (LAT + 3) tick(tag);
    endtask

    task automatic setup(int p0, int p1, int p2, int p3, int s0, int s1, int s2, int s3,
                         int bud, int lim);
        p_in[0] = p0; p_in[1] = p1; p_in[2] = p2; p_in[3] = p3;
        s_in[0] = s0; s_in[1] = s1; s_in[2] = s2; s_in[3] = s3;
        bud_in = bud;
        lim_in = lim;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) m_freq[c] = 64;
        setup(40, 50, 60, 70, 1, 2, 3, 4, 4000, 1023);
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        tick("R1");

        // R8: ample budget and limit, everyone at the ceiling
        run("R8");
        // R6: budget-limited greedy, tie between clusters 1 and 3
        setup(100, 100, 100, 100, 50, 200, 120, 200, 500, 1023);
        run("R6");
        // R5: tight headroom with mixed powers
        setup(30, 250, 90, 10, 255, 0, 128, 64, 700, 1023);
        run("R5");
        // R7: regulator limit binds before the budget
        setup(80, 80, 80, 80, 10, 20, 30, 40, 4000, 200);
        run("R7");
        // R7: limit below nominal keeps clusters at 64
        setup(120, 60, 200, 90, 5, 6, 7, 8, 4000, 100);
        run("R7");
        // R9: over budget, slowed in ascending scalability order
        setup(200, 150, 220, 180, 90, 30, 30, 200, 500, 1023);
        run("R9");
        // R9: zero budget drives all to the floor
        setup(255, 255, 1, 0, 9, 8, 7, 6, 0, 1023);
        run("R9");

        // R4: starts and input changes during a run are ignored
        setup(60, 70, 80, 90, 40, 30, 20, 10, 600, 1023);
        start = 1'b1;
        tick("R4");
        start = 1'b0;
        repeat (10) tick("R4");
        setup(200, 200, 200, 200, 1, 1, 1, 1, 0, 5);
        start = 1'b1;
        repeat (3) tick("R4");
        start = 1'b0;
        repeat (LAT) tick("R4");

        // R3: start held across done, new inputs captured only after done
        setup(50, 60, 70, 80, 100, 90, 80, 70, 4000, 1023);
        start = 1'b1;
        tick("R3");
        setup(100, 100, 100, 100, 7, 7, 7, 7, 450, 1023);
        repeat (2 * LAT + 4) tick("R3");
        start = 1'b0;
        repeat (LAT + 3) tick("R3");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule